// File: doc/BRIEF.md
# Hardware Semaphore Register Bank

This block holds a parameterised set of one-bit hardware semaphores behind a simple single-port register bus. Several processors share the bus and use the semaphores to guard common resources. A semaphore is taken by reading its register. The read returns the state the semaphore had before the access, and it marks the semaphore as held in the same access. A semaphore is handed back by writing zero to its register.

Software that reads a 1 has lost the race. It waits a short while and reads again, so a read of a held semaphore must change nothing. A read-only status word tells software how large the bank is. The size field sits in the top byte as a single set bit: 1, 2, 4 or 8. Multiplied by 32, that value gives the number of semaphores.

The bus has one port, so each access completes before the next one is seen. This makes every test-and-set atomic without further arbitration. Read data is registered and appears one cycle after the read strobe.

Top module: `hwsem_bank`

## Requirements
- R1: During reset and after its release every semaphore is free and `bus_rdata` is 0.
- R2: A read of a free semaphore returns 0 in `bus_rdata` on the cycle after the strobe, and the semaphore is held from that cycle on.
- R3: A read of a held semaphore returns 1 and leaves it held. Repeated reads have no further effect.
- R4: A write of 0x00000000 to a semaphore register frees that semaphore.
- R5: A write of any nonzero value to a semaphore register is ignored.
- R6: Semaphore i is at byte address 0x800 + 4*i, for i from 0 to NUM_LOCKS-1. Read data for a semaphore is 0 or 1 in bit 0, and all other bits are 0.
- R7: A read at byte address 0x014 returns NUM_LOCKS/32 in bits 31:24 and 0 in all other bits. A write to that address has no effect.
- R8: Accesses to any other address read as 0 and change no semaphore. This covers addresses with nonzero bits 1:0 and semaphore slots at or beyond NUM_LOCKS.
- R9: An access to one semaphore never changes any other semaphore.
- R10: When `bus_re` and `bus_we` are both high in the same cycle, the access is a read only and the write is discarded.
- R11: In a cycle that follows a cycle without `bus_re`, `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe; a read of a semaphore also acquires it |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_re` |

## Verification
The hardest case to reach is a write that arrives with a read strobe in the same cycle while the target semaphore is held. The write data is zero, so a design that lets the write through would silently free the semaphore. The stimulus first takes a semaphore, then issues this combined access. It then reads the semaphore again to show that it is still held. A long random phase crowds a few semaphores together with the status word and unmapped addresses, so that interleaved acquisitions, releases and stray accesses all meet the model.

// File: rtl/hwsem_pkg.sv
package hwsem_pkg;

  localparam int unsigned LOCK_REGION_BASE = 32'h0000_0800;
  localparam int unsigned STATUS_ADDR      = 32'h0000_0014;
  localparam int unsigned SIZE_FIELD_LSB   = 24;
  localparam int unsigned LOCKS_PER_UNIT   = 32;

  typedef enum logic [1:0] {
    RGN_NONE   = 2'd0,
    RGN_LOCK   = 2'd1,
    RGN_STATUS = 2'd2
  } hwsem_rgn_e;

  function automatic logic [31:0] size_word(input int unsigned n_locks);
    logic [7:0] units;
    units = 8'(n_locks / LOCKS_PER_UNIT);
    return {units, 24'h0};
  endfunction

endpackage

// File: rtl/hwsem_decode.sv
module hwsem_decode
  import hwsem_pkg::*;
#(
  parameter int unsigned NUM_LOCKS = 32,
  parameter int unsigned ADDR_W    = 12,
  localparam int unsigned IDX_W    = $clog2(NUM_LOCKS)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              re,
  input  logic              we,
  input  logic [31:0]       wdata,
  output hwsem_rgn_e        rgn,
  output logic [IDX_W-1:0]  idx,
  output logic              acq_en,
  output logic              rel_en
);

  localparam logic [ADDR_W-1:0] BASE_A   = ADDR_W'(LOCK_REGION_BASE);
  localparam logic [ADDR_W-1:0] STATUS_A = ADDR_W'(STATUS_ADDR);

  logic [ADDR_W-1:0] offset;
  logic              aligned;
  logic              in_lock;
  logic              in_status;

  always_comb begin
    offset    = addr - BASE_A;
    aligned   = (addr[1:0] == 2'b00);
    in_lock   = aligned && (addr >= BASE_A) &&
                (offset[ADDR_W-1:IDX_W+2] == '0);
    in_status = (addr == STATUS_A);
    idx       = offset[IDX_W+1:2];
    if (in_lock)        rgn = RGN_LOCK;
    else if (in_status) rgn = RGN_STATUS;
    else                rgn = RGN_NONE;
    acq_en = re && in_lock;
    rel_en = we && !re && in_lock && (wdata == 32'h0);
  end

endmodule

// File: rtl/hwsem_lock_array.sv
module hwsem_lock_array #(
  parameter int unsigned NUM_LOCKS = 32,
  localparam int unsigned IDX_W    = $clog2(NUM_LOCKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IDX_W-1:0]     idx,
  input  logic                 acq_en,
  input  logic                 rel_en,
  output logic [NUM_LOCKS-1:0] taken,
  output logic                 sel_taken
);

  for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_lock
    logic hit;
    logic ce;
    logic nxt;

    always_comb begin
      hit = (idx == IDX_W'(g));
      ce  = hit && (acq_en || rel_en);
      nxt = acq_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  taken[g] <= 1'b0;
      else if (ce) taken[g] <= nxt;
    end
  end

  assign sel_taken = taken[idx];

endmodule

// File: rtl/hwsem_rdata.sv
module hwsem_rdata
  import hwsem_pkg::*;
#(
  parameter int unsigned NUM_LOCKS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        re,
  input  hwsem_rgn_e  rgn,
  input  logic        sel_taken,
  output logic [31:0] rdata
);

  localparam logic [31:0] SIZE_WORD = size_word(NUM_LOCKS);

  logic [31:0] rdata_nxt;

  always_comb begin
    rdata_nxt = 32'h0;
    if (re) begin
      unique case (rgn)
        RGN_LOCK:   rdata_nxt = {31'h0, sel_taken};
        RGN_STATUS: rdata_nxt = SIZE_WORD;
        default:    rdata_nxt = 32'h0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= 32'h0;
    else        rdata <= rdata_nxt;
  end

endmodule

// File: rtl/hwsem_bank.sv
module hwsem_bank
  import hwsem_pkg::*;
#(
  parameter int unsigned NUM_LOCKS = 32,
  parameter int unsigned ADDR_W    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_re,
  output logic [31:0]       bus_rdata
);

  localparam int unsigned IDX_W = $clog2(NUM_LOCKS);

  hwsem_rgn_e           rgn;
  logic [IDX_W-1:0]     idx;
  logic                 acq_en;
  logic                 rel_en;
  logic                 sel_taken;
  logic [NUM_LOCKS-1:0] lock_taken;

  hwsem_decode #(.NUM_LOCKS(NUM_LOCKS), .ADDR_W(ADDR_W)) u_decode (
    .addr   (bus_addr),
    .re     (bus_re),
    .we     (bus_we),
    .wdata  (bus_wdata),
    .rgn    (rgn),
    .idx    (idx),
    .acq_en (acq_en),
    .rel_en (rel_en)
  );

  hwsem_lock_array #(.NUM_LOCKS(NUM_LOCKS)) u_locks (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx       (idx),
    .acq_en    (acq_en),
    .rel_en    (rel_en),
    .taken     (lock_taken),
    .sel_taken (sel_taken)
  );

  hwsem_rdata #(.NUM_LOCKS(NUM_LOCKS)) u_rdata (
    .clk       (clk),
    .rst_n     (rst_n),
    .re        (bus_re),
    .rgn       (rgn),
    .sel_taken (sel_taken),
    .rdata     (bus_rdata)
  );

endmodule

// File: rtl/hwsem_bank_chk.sv
module hwsem_bank_chk
  import hwsem_pkg::*;
#(
  parameter int unsigned NUM_LOCKS = 32,
  parameter int unsigned ADDR_W    = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 bus_we,
  input logic [31:0]          bus_wdata,
  input logic                 bus_re,
  input logic [31:0]          bus_rdata,
  input logic [NUM_LOCKS-1:0] taken
);

  localparam int unsigned IDX_W = $clog2(NUM_LOCKS);
  localparam logic [ADDR_W-1:0] BASE_A   = ADDR_W'(LOCK_REGION_BASE);
  localparam logic [ADDR_W-1:0] STATUS_A = ADDR_W'(STATUS_ADDR);

  logic [ADDR_W-1:0] rel_addr;
  logic              c_lock;
  logic [IDX_W-1:0]  c_idx;
  logic [IDX_W-1:0]  c_idx_q;

  always_comb begin
    rel_addr = bus_addr - BASE_A;
    c_lock   = (bus_addr[1:0] == 2'b00) && (bus_addr >= BASE_A) &&
               (32'(rel_addr >> 2) < NUM_LOCKS);
    c_idx    = rel_addr[IDX_W+1:2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) c_idx_q <= '0;
    else        c_idx_q <= c_idx;
  end

  // R2
  acquire_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re && c_lock && !taken[c_idx] |=> bus_rdata == 32'h0 && taken[c_idx_q]);

  // R3
  read_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re && c_lock && taken[c_idx] |=> bus_rdata == 32'h1 && $stable(taken));

  // R4
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && !bus_re && c_lock && bus_wdata == 32'h0 |=> !taken[c_idx_q]);

  // R5
  nonzero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && !bus_re && bus_wdata != 32'h0 |=> $stable(taken));

  // R8
  unmapped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re || bus_we) && !c_lock |=> $stable(taken));

  // R7
  size_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re && bus_addr == STATUS_A |=> bus_rdata == size_word(NUM_LOCKS));

  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> bus_rdata == 32'h0);

  // R9
  one_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(taken ^ $past(taken)) <= 1);

endmodule

bind hwsem_bank hwsem_bank_chk #(.NUM_LOCKS(NUM_LOCKS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_re    (bus_re),
  .bus_rdata (bus_rdata),
  .taken     (lock_taken)
);

// File: tb/hwsem_bank_bench.sv
module hwsem_bank_bench;

  localparam int NUM_LOCKS = 32;
  localparam int ADDR_W    = 12;
  localparam int BASE      = 'h800;
  localparam int STATUS    = 'h014;

  logic              clk;
  logic              rst_n;
  logic [ADDR_W-1:0] bus_addr;
  logic              bus_we;
  logic [31:0]       bus_wdata;
  logic              bus_re;
  logic [31:0]       bus_rdata;

  int vectors;
  int fails;
  bit finished;
  bit model_taken [NUM_LOCKS];

  hwsem_bank #(.NUM_LOCKS(NUM_LOCKS), .ADDR_W(ADDR_W)) u_hwsem_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int lock_of(input int a);
    if (a[1:0] != 2'b00) return -1;
    if (a < BASE || a >= BASE + 4 * NUM_LOCKS) return -1;
    return (a - BASE) / 4;
  endfunction

  task automatic check(input string req, input logic [31:0] exp);
    vectors++;
    if (bus_rdata !== exp) begin
      fails++;
      $display("FAIL %s: rdata=%h expected=%h", req, bus_rdata, exp);
    end
  endtask

  // one bus cycle: drive on falling edge, model the access, compare after the next falling edge
  task automatic access(input string req, input bit re, input bit we,
                        input int a, input logic [31:0] wd);
    int li;
    logic [31:0] exp;
    bus_addr  = ADDR_W'(a);
    bus_re    = re;
    bus_we    = we;
    bus_wdata = wd;
    li  = lock_of(a);
    exp = 32'h0;
    if (re) begin
      if (li >= 0) begin
        exp = {31'h0, model_taken[li]};
        model_taken[li] = 1'b1;
      end else if (a == STATUS) begin
        exp = 32'(NUM_LOCKS / 32) << 24;
      end
    end else if (we && li >= 0 && wd == 32'h0) begin
      model_taken[li] = 1'b0;
    end
    @(negedge clk);
    check(req, exp);
  endtask

  task automatic rd(input string req, input int a);
    access(req, 1'b1, 1'b0, a, 32'h0);
  endtask

  task automatic wr(input string req, input int a, input logic [31:0] wd);
    access(req, 1'b0, 1'b1, a, wd);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    vectors  = 0;
    fails    = 0;
    finished = 1'b0;
    for (int i = 0; i < NUM_LOCKS; i++) model_taken[i] = 1'b0;
    rst_n     = 1'b0;
    bus_addr  = '0;
    bus_re    = 1'b0;
    bus_we    = 1'b0;
    bus_wdata = 32'h0;
    repeat (3) @(negedge clk);
    check("R1", 32'h0);
    rst_n = 1'b1;
    access("R1", 1'b0, 1'b0, 0, 32'h0);

    // R1/R2 every slot starts free and is taken by its first read; R6 map
    for (int i = 0; i < NUM_LOCKS; i++) rd("R2", BASE + 4 * i);
    for (int i = 0; i < NUM_LOCKS; i++) rd("R3", BASE + 4 * i);
    for (int i = 0; i < NUM_LOCKS; i++) wr("R4", BASE + 4 * i, 32'h0);
    for (int i = 0; i < NUM_LOCKS; i++) rd("R6", BASE + 4 * i);
    for (int i = 0; i < NUM_LOCKS; i++) wr("R4", BASE + 4 * i, 32'h0);

    // R2 then R3 on one slot, R9 neighbour untouched
    rd("R2", BASE + 4 * 5);
    rd("R3", BASE + 4 * 5);
    rd("R9", BASE + 4 * 6);
    wr("R5", BASE + 4 * 5, 32'h1);
    rd("R5", BASE + 4 * 5);
    wr("R5", BASE + 4 * 5, 32'h8000_0000);
    rd("R5", BASE + 4 * 5);
    wr("R4", BASE + 4 * 5, 32'h0);
    rd("R4", BASE + 4 * 5);
    rd("R9", BASE + 4 * 6);

    // R7 size word, write has no effect
    rd("R7", STATUS);
    wr("R7", STATUS, 32'hFFFF_FFFF);
    rd("R7", STATUS);

    // R8 unmapped and misaligned
    rd("R8", 'h000);
    rd("R8", 'h7FC);
    rd("R8", BASE + 4 * NUM_LOCKS);
    rd("R8", 'h802);
    rd("R8", 'hFFC);
    rd("R2", BASE);
    wr("R8", 'h802, 32'h0);
    wr("R8", 'h801, 32'h0);
    rd("R8", BASE);

    // R10 combined strobes on a held slot: read only
    access("R10", 1'b1, 1'b1, BASE, 32'h0);
    rd("R10", BASE);

    // R11 idle cycles
    access("R11", 1'b0, 1'b0, BASE, 32'h0);
    access("R11", 1'b0, 1'b0, STATUS, 32'h0);

    // random mix over a few slots, the size word and stray addresses
    for (int n = 0; n < 3000; n++) begin
      int sel;
      int a;
      bit r;
      bit w;
      logic [31:0] d;
      sel = int'($urandom % 8);
      if (sel < 4)       a = BASE + 4 * sel;
      else if (sel == 4) a = STATUS;
      else if (sel == 5) a = BASE + 4 * NUM_LOCKS;
      else if (sel == 6) a = BASE + 1;
      else               a = BASE + 4 * (NUM_LOCKS - 1);
      r = ($urandom % 2) == 0;
      w = ($urandom % 3) != 0;
      d = (($urandom % 4) == 0) ? $urandom : 32'h0;
      access("R9", r, w, a, d);
    end

    finish_run();
  end

endmodule